// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This block computes the integer quotient of two 32-bit operands over several clock cycles. A single control input chooses the mode. In unsigned mode both operands are plain binary magnitudes. In signed mode they are two's complement values, the quotient truncates toward zero, and its sign is the exclusive-or of the operand signs. The block produces one quotient bit per cycle using a restoring shift-and-subtract loop, and it reports completion with a one-cycle done pulse.

The divisor is checked for zero before any iteration starts. If it is zero, no iteration runs. The quotient becomes 0, a sticky divide-by-zero flag is set, and done follows at once. An exception request is raised only when the caller enables exceptions and the configuration mask for this trap is clear. In that case the exception cause output is loaded with the divide-by-zero code. Any later accepted operation with a nonzero divisor clears the flag.

Top module: `int_div_unit`

## Requirements
- R1: After reset, busy_o, done_o, exc_req_o and divz_flag_o are 0, and quotient_o and exc_cause_o are all zeros.
- R2: An operation is accepted when start_i is high at a rising edge while busy_o is low. With a nonzero divisor, busy_o is high from the cycle after that edge until done_o rises. done_o is high in the cycle that follows the 32nd rising edge after the accepting edge.
- R3: In unsigned mode (signed_i = 0), quotient_o equals dividend_i / divisor_i, rounded down.
- R4: In signed mode (signed_i = 1), quotient_o is the two's complement quotient, truncated toward zero. It is negative when exactly one operand is negative.
- R5: In signed mode, 0x80000000 divided by 0xFFFFFFFF (-1) returns 0x80000000.
- R6: With a zero divisor, no iteration runs. busy_o stays low, done_o is high in the cycle right after the accepting edge, and quotient_o is 0.
- R7: divz_flag_o is set by an accepted zero-divisor operation and cleared by an accepted nonzero-divisor operation, both at the accepting edge. Between accepted operations it holds its value.
- R8: exc_req_o is high together with done_o for a zero-divisor operation only when exc_en_i = 1 and divz_mask_i = 0. Both inputs are sampled at the accepting edge. exc_req_o is never high in any other cycle.
- R9: When an exception is raised, exc_cause_o is loaded with code 5 (5'b00101). At all other times exc_cause_o keeps its value.
- R10: start_i is ignored while busy_o is high. The running operation still returns its own quotient, and no extra done_o pulse is produced.
- R11: done_o is a one-cycle pulse for each accepted operation. quotient_o changes only at the edge that raises done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division (taken when idle) |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_i | input | 32 | Dividend, captured at accept |
| divisor_i | input | 32 | Divisor, captured at accept |
| exc_en_i | input | 1 | Global exception enable |
| divz_mask_i | input | 1 | Configuration mask; 1 suppresses the divide-by-zero exception |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Quotient of the last completed operation |
| divz_flag_o | output | 1 | Sticky divide-by-zero status |
| exc_req_o | output | 1 | Exception request, pulses with done_o |
| exc_cause_o | output | 5 | Exception cause code, held |

## Verification
The assertions assume that reset is applied once at time zero and that every input is a defined value at each rising edge. They make no assumption about holding the operands steady, because the block captures them at the accepting edge. The stimulus changes inputs only on falling clock edges and holds start_i for one cycle. It waits for each done pulse before issuing the next operation. The one exception is a deliberate start issued mid-operation to check that it is ignored.

// File: rtl/int_div_pkg.sv
package int_div_pkg;
    localparam int unsigned DIV_W      = 32;
    localparam int unsigned CAUSE_W    = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_DIVZ = 5'd5;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_q_o,
    output logic         zero_div_o
);
    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg      = signed_i & dividend_i[W-1];
        b_neg      = signed_i & divisor_i[W-1];
        mag_a_o    = a_neg ? (~dividend_i + W'(1)) : dividend_i;
        mag_b_o    = b_neg ? (~divisor_i + W'(1)) : divisor_i;
        neg_q_o    = a_neg ^ b_neg;
        zero_div_o = (divisor_i == '0);
    end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] work_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] work_o
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       take;

    always_comb begin
        shifted = {rem_i, work_i[W-1]};
        diff    = shifted - {1'b0, dvs_i};
        take    = ~diff[W];
        rem_o   = take ? diff[W-1:0] : shifted[W-1:0];
        work_o  = {work_i[W-2:0], take};
    end
endmodule

// File: rtl/div_zero_trap.sv
module div_zero_trap #(
    parameter int unsigned CW   = 5,
    parameter logic [CW-1:0] CODE = 5'd5
) (
    input  logic          zero_div_i,
    input  logic          exc_en_i,
    input  logic          mask_i,
    output logic          raise_o,
    output logic [CW-1:0] code_o
);
    always_comb begin
        raise_o = zero_div_i & exc_en_i & ~mask_i;
        code_o  = CODE;
    end
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
    import int_div_pkg::*;
#(
    parameter int unsigned W  = DIV_W,
    parameter int unsigned CW = CAUSE_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          signed_i,
    input  logic [W-1:0]  dividend_i,
    input  logic [W-1:0]  divisor_i,
    input  logic          exc_en_i,
    input  logic          divz_mask_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  quotient_o,
    output logic          divz_flag_o,
    output logic          exc_req_o,
    output logic [CW-1:0] exc_cause_o
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             exc;
        logic             dz;
        logic [CW-1:0]    cause;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     work;
        logic [W-1:0]     dvs;
        logic             neg;
        logic [W-1:0]     quot;
    } div_regs_t;

    div_regs_t r_d, r_q;

    logic [W-1:0]  mag_a, mag_b;
    logic          neg_q, zero_div;
    logic [W-1:0]  rem_nxt, work_nxt;
    logic          raise;
    logic [CW-1:0] trap_code;

    div_operand_prep #(.W(W)) prep_i (
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .signed_i   (signed_i),
        .mag_a_o    (mag_a),
        .mag_b_o    (mag_b),
        .neg_q_o    (neg_q),
        .zero_div_o (zero_div)
    );

    div_restore_step #(.W(W)) step_i (
        .rem_i  (r_q.rem),
        .work_i (r_q.work),
        .dvs_i  (r_q.dvs),
        .rem_o  (rem_nxt),
        .work_o (work_nxt)
    );

    div_zero_trap #(.CW(CW), .CODE(CW'(CAUSE_DIVZ))) trap_i (
        .zero_div_i (zero_div),
        .exc_en_i   (exc_en_i),
        .mask_i     (divz_mask_i),
        .raise_o    (raise),
        .code_o     (trap_code)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.exc  = 1'b0;
        if (!r_q.busy) begin
            if (start_i) begin
                if (zero_div) begin
                    r_d.done = 1'b1;
                    r_d.dz   = 1'b1;
                    r_d.quot = '0;
                    if (raise) begin
                        r_d.exc   = 1'b1;
                        r_d.cause = trap_code;
                    end
                end else begin
                    r_d.busy = 1'b1;
                    r_d.dz   = 1'b0;
                    r_d.cnt  = CNT_W'(W);
                    r_d.rem  = '0;
                    r_d.work = mag_a;
                    r_d.dvs  = mag_b;
                    r_d.neg  = neg_q;
                end
            end
        end else begin
            r_d.rem  = rem_nxt;
            r_d.work = work_nxt;
            r_d.cnt  = r_q.cnt - CNT_W'(1);
            if (r_q.cnt == CNT_W'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.quot = r_q.neg ? (~work_nxt + W'(1)) : work_nxt;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign busy_o      = r_q.busy;
    assign done_o      = r_q.done;
    assign quotient_o  = r_q.quot;
    assign divz_flag_o = r_q.dz;
    assign exc_req_o   = r_q.exc;
    assign exc_cause_o = r_q.cause;

    // checker state: length of the current busy run
    logic [CNT_W:0] busy_len_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     busy_len_q <= '0;
        else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
        else             busy_len_q <= '0;
    end

    logic accept;
    assign accept = start_i && !busy_o;

    AST_BUSY_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_len_q <= (CNT_W+1)'(W)); // R2
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> done_o); // R2
    AST_NOT_BUSY_AND_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) !(busy_o && done_o)); // R11
    AST_ZERO_DIV_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept && divisor_i == '0 |=> done_o && !busy_o && divz_flag_o && quotient_o == '0); // R6
    AST_NZ_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept && divisor_i != '0 |=> busy_o && !divz_flag_o); // R7
    AST_EXC_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept && divisor_i == '0 && exc_en_i && !divz_mask_i |=> exc_req_o && exc_cause_o == CW'(CAUSE_DIVZ)); // R9
    AST_EXC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept && !(divisor_i == '0 && exc_en_i && !divz_mask_i) |=> !exc_req_o); // R8
    AST_EXC_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) exc_req_o |-> done_o && divz_flag_o); // R8
    AST_CAUSE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) !exc_req_o |-> $stable(exc_cause_o) || $past(!rst_ni)); // R9
    AST_QUOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) !done_o |-> $stable(quotient_o) || $past(!rst_ni)); // R11
    AST_FLAG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) !$past(accept) |-> $stable(divz_flag_o) || $past(!rst_ni)); // R7
endmodule

// File: tb/int_div_unit_tb_top.sv
module int_div_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sgn = 1'b0;
    logic [31:0] dvd = '0;
    logic [31:0] dvs = '0;
    logic        exc_en = 1'b0;
    logic        mask = 1'b0;
    logic        busy, done, dz, exc_req;
    logic [31:0] quot;
    logic [4:0]  cause;

    always #10 clk = ~clk;   // 50 MHz

    int_div_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
        .dividend_i(dvd), .divisor_i(dvs), .exc_en_i(exc_en), .divz_mask_i(mask),
        .busy_o(busy), .done_o(done), .quotient_o(quot), .divz_flag_o(dz),
        .exc_req_o(exc_req), .exc_cause_o(cause)
    );

    typedef struct {
        logic [31:0] q;
        logic        dz;
        logic        exc;
        logic [4:0]  cause;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc_cnt = 0;
    logic [4:0] m_cause = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    function automatic logic [31:0] model_q(input logic [31:0] a, input logic [31:0] b, input bit s);
        if (b == 0) return 32'h0;
        if (!s) return a / b;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        return $signed(a) / $signed(b);
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit s,
                          input bit en, input bit msk, input string tag);
        exp_t e;
        @(negedge clk);
        e.q   = model_q(a, b, s);
        e.dz  = (b == 0);
        e.exc = (b == 0) && en && !msk;
        if (e.exc) m_cause = 5'd5;
        e.cause = m_cause;
        e.cyc = cyc_cnt + 1 + ((b == 0) ? 0 : 32);
        e.tag = tag;
        sb_q.push_back(e);
        dvd = a; dvs = b; sgn = s; exc_en = en; mask = msk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // monitor: pops expected items as done pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (exc_req && !done) check(1'b0, "R8 exc_req without done", 32'(exc_req), 32'h0);
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 32'(done), 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(quot == e.q, {e.tag, " quotient"}, quot, e.q);
                    check(dz == e.dz, "R7 divz flag at done", 32'(dz), 32'(e.dz));
                    check(exc_req == e.exc, "R8 exc_req", 32'(exc_req), 32'(e.exc));
                    check(cause == e.cause, "R9 cause", 32'(cause), 32'(e.cause));
                    check(cyc_cnt == e.cyc, "R2 R6 done latency", 32'(cyc_cnt), 32'(e.cyc));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(cyc_cnt), 32'h0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && exc_req == 0 && dz == 0, "R1 control outputs",
              {28'h0, busy, done, exc_req, dz}, 32'h0);
        check(quot == 0 && cause == 0, "R1 data outputs", quot | 32'(cause), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 unsigned
        run_op(32'd100, 32'd7, 0, 0, 0, "R3");
        run_op(32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R3");
        run_op(32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, 0, 0, "R3");
        run_op(32'd5, 32'd9, 0, 0, 0, "R3");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0, "R3");

        // R4 signed
        run_op(32'hFFFF_FF9C, 32'd7, 1, 0, 0, "R4");         // -100/7 = -14
        run_op(32'd100, 32'hFFFF_FFF9, 1, 0, 0, "R4");       // 100/-7 = -14
        run_op(32'hFFFF_FF9C, 32'hFFFF_FFF9, 1, 0, 0, "R4"); // 14
        run_op(32'h8000_0000, 32'd1, 1, 0, 0, "R4");

        // R5 overflow corner
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, 0, "R5");

        // R6/R8/R9 zero divisor, exception variants
        run_op(32'd123, 32'd0, 0, 0, 0, "R6");
        run_op(32'd123, 32'd0, 1, 1, 1, "R6 masked");
        run_op(32'd456, 32'd0, 0, 1, 0, "R9 raised");
        run_op(32'd789, 32'd0, 1, 1, 1, "R9 held");

        // R7 sticky flag
        repeat (4) @(negedge clk);
        check(dz == 1'b1, "R7 flag sticky when idle", 32'(dz), 32'h1);
        check(cause == 5'd5, "R9 cause held when idle", 32'(cause), 32'h5);
        begin
            exp_t e;
            @(negedge clk);
            e.q = 32'd3; e.dz = 0; e.exc = 0; e.cause = m_cause;
            e.cyc = cyc_cnt + 33; e.tag = "R7";
            sb_q.push_back(e);
            dvd = 32'd9; dvs = 32'd3; sgn = 0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(dz == 1'b0, "R7 flag cleared at accept", 32'(dz), 32'h0);
            check(busy == 1'b1, "R2 busy during iteration", 32'(busy), 32'h1);
            while (sb_q.size() != 0) @(negedge clk);
        end

        // R10 start ignored while busy
        begin
            exp_t e;
            @(negedge clk);
            e.q = 32'd1000; e.dz = 0; e.exc = 0; e.cause = m_cause;
            e.cyc = cyc_cnt + 33; e.tag = "R10";
            sb_q.push_back(e);
            dvd = 32'd5000; dvs = 32'd5; sgn = 0; exc_en = 1; mask = 0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            dvd = 32'd7; dvs = 32'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(dz == 1'b0, "R10 flag untouched by ignored start", 32'(dz), 32'h0);
            while (sb_q.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            check(done == 1'b0 && exc_req == 1'b0, "R10 no extra done", {30'h0, done, exc_req}, 32'h0);
        end

        // R11 quotient held after done
        repeat (3) @(negedge clk);
        check(quot == 32'd1000, "R11 quotient held", quot, 32'd1000);

        // mixed operands
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            a = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            b = (i % 3 == 0) ? (lfsr >> (lfsr[4:0])) : lfsr;
            if (i % 10 == 7) b = 32'h0;
            run_op(a, b, i[0], i[1], i[2], i[0] ? "R4 mixed" : "R3 mixed");
        end

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule